// File: doc/BRIEF.md
# Memory-Scanning CRC32 Engine

This block computes a CRC32 checksum over a contiguous run of 32-bit memory words without processor involvement. Software programs a start location, a word count and a seed value through a small register interface, then writes the go bit. The engine fetches the words one at a time over a read port with a valid/ready request handshake and a response carrying data and an error flag. Each returned word is folded into the running remainder in a single clock cycle.

The engine uses the reflected CRC32 polynomial 0xEDB88320, which is 0x04C11DB7 with its bits reversed. It consumes each word least significant bit first, so the bytes are taken little-endian. The seed and the running remainder share one register. That register always holds the raw remainder, and software complements it to get the standard CRC-32. Completion, failure and bus errors are reported through sticky flags that software clears by writing ones.

Top module: `crcscan_top`

## Requirements
- R1: After reset, every register reads zero (select 0 go, 1 status, 2 start, 3 count, 4 remainder) and no memory request is raised.
- R2: The word index is start register bits 31:2 and the word count is count register bits 31:2. A scan requests exactly that many words, starting at the index and stepping up by one each time.
- R3: Each word is folded with the reflected polynomial 0xEDB88320, LSB first, starting from the remainder register. That register returns the raw remainder with no final inversion, so its complement for the bytes "12345678" is the standard CRC-32.
- R4: Writing the go register with bit 0 set while idle starts a scan. A write with bit 0 clear starts nothing.
- R5: Status bits are done (0), fail (1), bus error (2) and busy (3, read-only). Writing 1 to any of bits 2:0 clears that flag only. A flag being set in the same cycle wins over a clear.
- R6: If bits 1:0 of the start register or of the count register are nonzero, go sets fail and bus error, issues no request and leaves the remainder unchanged.
- R7: An error response ends the scan at once and sets fail and bus error without done. No further request follows, and the remainder keeps the value folded from the earlier words.
- R8: A count of zero sets done at once, issues no request and leaves the remainder unchanged.
- R9: While busy, writes to the go, start, count and remainder registers are ignored. Status clear writes still take effect.
- R10: A raised request holds its valid and address stable until ready is seen, and only one request is outstanding at a time.
- R11: Done is set when the last word has been folded, and busy then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 go, 1 status, 2 start, 3 count, 4 remainder) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word index being requested |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 32 | Response data word |
| mem_rsp_err | input | 1 | Response carries an error |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request and never raises a response while no request is pending. They also assume that register selects stay within the five defined offsets. The bench memory model only answers after it has seen a request accepted, and it waits a varying number of cycles before replying. Its ready signal stalls on a fixed cycle pattern, which exercises the hold rule. Register writes only use defined selects.

// File: rtl/crcscan_pkg.sv
package crcscan_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam int          SEL_W         = 3;

  localparam logic [SEL_W-1:0] SEL_GO    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STAT  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_START = 3'd2;
  localparam logic [SEL_W-1:0] SEL_COUNT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_REM   = 3'd4;

  localparam int FLG_DONE = 0;
  localparam int FLG_FAIL = 1;
  localparam int FLG_BERR = 2;
  localparam int FLG_BUSY = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/crcscan_rst_sync.sv
module crcscan_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/crcscan_fold.sv
module crcscan_fold #(
  parameter int DW = 32
) (
  input  logic [31:0]   crc_in,
  input  logic [DW-1:0] word_in,
  output logic [31:0]   crc_out
);
  import crcscan_pkg::*;

  logic [DW:0][31:0] chain;

  assign chain[0] = crc_in;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic fb;
    assign fb           = chain[b][0] ^ word_in[b];
    assign chain[b+1]   = {1'b0, chain[b][31:1]} ^ (CRC_POLY_REFL & {32{fb}});
  end

  assign crc_out = chain[DW];

endmodule

// File: rtl/crcscan_regs.sv
module crcscan_regs #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              fold_en,
  input  logic [31:0]       fold_crc,
  input  logic              set_done,
  input  logic              set_fail,
  input  logic              set_berr,
  output logic              start_go,
  output logic [ADDR_W-1:0] start_word_addr,
  output logic [LEN_W-1:0]  start_words,
  output logic              start_misaligned,
  output logic [31:0]       crc_cur
);
  import crcscan_pkg::*;

  logic [31:0] start_q, count_q, rem_q;
  logic        done_q, fail_q, berr_q;

  logic        wr_ok;
  logic        start_en, count_en, rem_en, flag_en;
  logic [31:0] rem_d;
  logic [2:0]  clr;
  logic        done_d, fail_d, berr_d;

  always_comb begin
    wr_ok    = reg_wen && !busy;
    start_en = wr_ok && (reg_sel == SEL_START);
    count_en = wr_ok && (reg_sel == SEL_COUNT);
    rem_en   = fold_en || (wr_ok && (reg_sel == SEL_REM));
    rem_d    = fold_en ? fold_crc : reg_wdata;
    start_go = wr_ok && (reg_sel == SEL_GO) && reg_wdata[0];
    clr      = (reg_wen && (reg_sel == SEL_STAT)) ? reg_wdata[2:0] : 3'b000;
    done_d   = set_done || (done_q && !clr[FLG_DONE]);
    fail_d   = set_fail || (fail_q && !clr[FLG_FAIL]);
    berr_d   = set_berr || (berr_q && !clr[FLG_BERR]);
    flag_en  = set_done || set_fail || set_berr || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      if (start_en) start_q <= reg_wdata;
      if (count_en) count_q <= reg_wdata;
      if (rem_en)   rem_q   <= rem_d;
      if (flag_en) begin
        done_q <= done_d;
        fail_q <= fail_d;
        berr_q <= berr_d;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_STAT:  reg_rdata = {28'd0, busy, berr_q, fail_q, done_q};
      SEL_START: reg_rdata = start_q;
      SEL_COUNT: reg_rdata = count_q;
      SEL_REM:   reg_rdata = rem_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign start_word_addr  = start_q[ADDR_W+1:2];
  assign start_words      = count_q[LEN_W+1:2];
  assign start_misaligned = (|start_q[1:0]) || (|count_q[1:0]);
  assign crc_cur          = rem_q;

  // R9: with the engine busy and no fold, the remainder cannot move
  p_rem_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fold_en) |=> $stable(rem_q));

  // R9: programming registers hold while busy
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(start_q) && $stable(count_q)));

  // R5: a flag raised by the sequencer is visible the next cycle
  p_flag_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_fail || set_berr) |=> (fail_q || !$past(set_fail)) && (berr_q || !$past(set_berr)));

  // R11: done flag follows a completion pulse
  p_done_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done_q);

endmodule

// File: rtl/crcscan_seq.sv
module crcscan_seq #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [ADDR_W-1:0] start_word_addr,
  input  logic [LEN_W-1:0]  start_words,
  input  logic              start_misaligned,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              fold_en,
  output logic              set_done,
  output logic              set_fail,
  output logic              set_berr
);
  import crcscan_pkg::*;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              load, step, cnt_en;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    step     = 1'b0;
    fold_en  = 1'b0;
    set_done = 1'b0;
    set_fail = 1'b0;
    set_berr = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_go) begin
          if (start_misaligned) begin
            set_fail = 1'b1;
            set_berr = 1'b1;
          end else if (start_words == '0) begin
            set_done = 1'b1;
          end else begin
            load    = 1'b1;
            state_d = SQ_REQ;
          end
        end
      end
      SQ_REQ: begin
        if (mem_req_ready) state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            set_fail = 1'b1;
            set_berr = 1'b1;
            state_d  = SQ_IDLE;
          end else begin
            fold_en = 1'b1;
            step    = 1'b1;
            if (remain_q == LEN_W'(1)) begin
              set_done = 1'b1;
              state_d  = SQ_IDLE;
            end else begin
              state_d = SQ_REQ;
            end
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    cnt_en     = load || step;
    cur_addr_d = load ? start_word_addr : cur_addr_q + ADDR_W'(1);
    remain_d   = load ? start_words     : remain_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cur_addr_q <= cur_addr_d;
        remain_q   <= remain_d;
      end
    end
  end

  assign busy          = (state_q != SQ_IDLE);
  assign mem_req_valid = (state_q == SQ_REQ);
  assign mem_req_addr  = cur_addr_q;

  // R10: request held with a stable address until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: no new request while a response is still owed
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R7: an error response returns the engine to idle at once
  p_err_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && mem_rsp_valid && mem_rsp_err) |=> (!busy && !mem_req_valid));

  // R2: consecutive requests step the word index by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && !set_done) |=> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(1)));

  // R11: completion and failure never reported together
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_done && set_fail));

endmodule

// File: rtl/crcscan_top.sv
module crcscan_top #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_err
);

  logic              rst_n_s;
  logic              busy, fold_en;
  logic              set_done, set_fail, set_berr;
  logic              start_go, start_misaligned;
  logic [ADDR_W-1:0] start_word_addr;
  logic [LEN_W-1:0]  start_words;
  logic [31:0]       crc_cur, fold_crc;

  crcscan_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  crcscan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk              (clk),
    .rst_n            (rst_n_s),
    .reg_wen          (reg_wen),
    .reg_sel          (reg_sel),
    .reg_wdata        (reg_wdata),
    .reg_rdata        (reg_rdata),
    .busy             (busy),
    .fold_en          (fold_en),
    .fold_crc         (fold_crc),
    .set_done         (set_done),
    .set_fail         (set_fail),
    .set_berr         (set_berr),
    .start_go         (start_go),
    .start_word_addr  (start_word_addr),
    .start_words      (start_words),
    .start_misaligned (start_misaligned),
    .crc_cur          (crc_cur)
  );

  crcscan_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n_s),
    .start_go         (start_go),
    .start_word_addr  (start_word_addr),
    .start_words      (start_words),
    .start_misaligned (start_misaligned),
    .busy             (busy),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr),
    .mem_rsp_valid    (mem_rsp_valid),
    .mem_rsp_err      (mem_rsp_err),
    .fold_en          (fold_en),
    .set_done         (set_done),
    .set_fail         (set_fail),
    .set_berr         (set_berr)
  );

  crcscan_fold #(.DW(32)) u_fold (
    .crc_in  (crc_cur),
    .word_in (mem_rsp_data),
    .crc_out (fold_crc)
  );

endmodule

// File: tb/crcscan_top_tb_top.sv
module crcscan_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wen = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          mem_rsp_err = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [64];
  int          req_count = 0;
  int          first_addr = -1;
  int          hold_viol = 0;
  logic        err_en = 1'b0;
  int          err_word = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crcscan_top #(.ADDR_W(AW), .LEN_W(30)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wen       (reg_wen),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err)
  );

  // memory model: acts at negedges on what the DUT showed since the last posedge
  initial begin
    logic          last_valid;
    logic [AW-1:0] last_addr;
    logic          pending;
    logic [AW-1:0] paddr;
    int            lat;
    int            cyc;
    last_valid = 1'b0; last_addr = '0; pending = 1'b0; paddr = '0; lat = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (last_valid && mem_req_ready) begin
        pending = 1'b1;
        paddr   = last_addr;
        lat     = cyc % 2;
        if (req_count == 0) first_addr = int'(last_addr);
        req_count++;
      end else if (last_valid && !mem_req_ready) begin
        if (!mem_req_valid || mem_req_addr !== last_addr) hold_viol++;
      end
      if (pending) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[paddr[5:0]];
          mem_rsp_err   = err_en && (int'(paddr) == err_word);
          pending       = 1'b0;
        end else begin
          lat--;
        end
      end
      mem_req_ready = (cyc % 3) != 1;
      last_valid    = mem_req_valid;
      last_addr     = mem_req_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, s);
      if (!s[3]) return;
    end
  endtask

  function automatic logic [31:0] mfold(input logic [31:0] c, input logic [31:0] d, input int nb);
    for (int i = 0; i < nb; i++)
      c = (c >> 1) ^ (((c[0] ^ d[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
    return c;
  endfunction

  function automatic logic [31:0] mrun(input logic [31:0] seed, input int a, input int n);
    logic [31:0] c;
    c = seed;
    for (int i = 0; i < n; i++) c = mfold(c, mem[(a + i) % 64], 32);
    return c;
  endfunction

  task automatic scan(input int a, input int n, input logic [31:0] seed);
    wr(3'd1, 32'h7);
    wr(3'd2, a * 4);
    wr(3'd3, n * 4);
    wr(3'd4, seed);
    @(negedge clk);
    req_count = 0; first_addr = -1;
    wr(3'd0, 32'h1);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 no request", {31'd0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_known();
    logic [31:0] v, c;
    mem[0] = 32'h34333231;
    mem[1] = 32'h38373635;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 9; b++) c = mfold(c, 32'h31 + b, 8);
    chk("R3 model check 123456789", ~c, 32'hCBF43926);
    scan(0, 2, 32'hFFFFFFFF);
    rd(3'd4, v);
    chk("R3 CRC-32 of 12345678", ~v, ~mrun(32'hFFFFFFFF, 0, 2));
    rd(3'd1, v);
    chk("R11 done and not busy", v, 32'h1);
    chk("R2 request count", req_count, 2);
  endtask

  task automatic t_random();
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    scan(10, 20, 32'hFFFFFFFF);
    rd(3'd4, v);
    chk("R3 random block", v, mrun(32'hFFFFFFFF, 10, 20));
    chk("R2 first word index", first_addr, 10);
    chk("R2 request count", req_count, 20);
    scan(50, 14, 32'h12345678);
    rd(3'd4, v);
    chk("R3 raw remainder odd seed", v, mrun(32'h12345678, 50, 14));
    chk("R2 wrap request count", req_count, 14);
  endtask

  task automatic t_nogo();
    logic [31:0] v;
    wr(3'd1, 32'h7);
    req_count = 0;
    wr(3'd3, 32'h10);
    wr(3'd0, 32'h0);
    rd(3'd1, v);
    chk("R4 go bit clear starts nothing", v, 32'h0);
    repeat (4) @(negedge clk);
    chk("R4 no request", req_count, 0);
  endtask

  task automatic t_misaligned();
    logic [31:0] v;
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h41); wr(3'd3, 32'h8); wr(3'd4, 32'h11223344);
    req_count = 0;
    wr(3'd0, 32'h1);
    rd(3'd1, v);
    chk("R6 start misaligned flags", v, 32'h6);
    rd(3'd4, v);
    chk("R6 remainder unchanged", v, 32'h11223344);
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h40); wr(3'd3, 32'h7);
    wr(3'd0, 32'h1);
    rd(3'd1, v);
    chk("R6 count misaligned flags", v, 32'h6);
    repeat (4) @(negedge clk);
    chk("R6 no request", req_count, 0);
  endtask

  task automatic t_zero_and_w1c();
    logic [31:0] v;
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'hCAFEF00D);
    req_count = 0;
    wr(3'd0, 32'h1);
    rd(3'd1, v);
    chk("R8 zero count done", v, 32'h1);
    rd(3'd4, v);
    chk("R8 remainder unchanged", v, 32'hCAFEF00D);
    chk("R8 no request", req_count, 0);
    wr(3'd3, 32'h3);
    wr(3'd0, 32'h1);
    rd(3'd1, v);
    chk("R5 all flags set", v, 32'h7);
    wr(3'd1, 32'h2);
    rd(3'd1, v);
    chk("R5 clear fail only", v, 32'h5);
    wr(3'd1, 32'h9);
    rd(3'd1, v);
    chk("R5 clear done, busy bit ignored", v, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd1, v);
    chk("R5 clear bus error", v, 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    err_en = 1'b1; err_word = 5;
    scan(3, 6, 32'hFFFFFFFF);
    rd(3'd1, v);
    chk("R7 error flags without done", v, 32'h6);
    rd(3'd4, v);
    chk("R7 partial remainder", v, mrun(32'hFFFFFFFF, 3, 2));
    repeat (6) @(negedge clk);
    chk("R7 no request after error", req_count, 3);
    err_en = 1'b0;
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h3);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h0); wr(3'd3, 32'd120); wr(3'd4, 32'hFFFFFFFF);
    req_count = 0;
    wr(3'd0, 32'h1);
    rd(3'd1, v);
    chk("R9 busy with old flags", v, 32'hE);
    wr(3'd4, 32'hDEADBEEF);
    wr(3'd2, 32'h100);
    wr(3'd3, 32'h8);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h6);
    rd(3'd1, v);
    chk("R9 clear during busy", v, 32'h8);
    wait_idle();
    rd(3'd2, v);
    chk("R9 start register kept", v, 32'h0);
    rd(3'd3, v);
    chk("R9 count register kept", v, 32'd120);
    rd(3'd4, v);
    chk("R9 result uses original seed", v, mrun(32'hFFFFFFFF, 0, 30));
    chk("R9 no restart", req_count, 30);
    rd(3'd1, v);
    chk("R11 done after long scan", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_known();
    t_random();
    t_nogo();
    t_misaligned();
    t_zero_and_w1c();
    t_err();
    t_busy();
    chk("R10 request hold violations", hold_viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule